// File: doc/BRIEF.md
# Per-Port Idle Packet Colour Tracker

This block chooses the colour bit that each output port of an N-by-N packet switch puts into the idle packets it sends. Software programs an expected colour and issues a clear strobe. From the clear onward every port advertises the colour opposite to the expected one. A port moves to the expected colour only when both of these hold: every input has received at least one packet carrying the expected colour since the clear, and that port's output queue is empty.

The first condition is shared by all ports. The second belongs to each port alone, so ports change over at different times as their queues drain. Once a port has changed over, it keeps the expected colour until the next clear. The outputs are registered. Packet building and framing are handled elsewhere.

Top module: `idle_colour_tracker`

## Requirements
- R1: While reset is asserted, every idle colour output reads 0 and all tracking state is cleared. After reset is released and before any clear, a port does not change over until every input has seen the expected colour again.
- R2: In the cycle after a clear strobe, every port outputs the inverse of the expected colour that was present with the strobe.
- R3: A port outputs the expected colour one clock after a cycle in which two things hold: every input has a recorded or simultaneous arrival of the expected colour, and that port's queue-empty flag is high.
- R4: An arrival counts only when its valid bit is 1 and its colour bit equals the expected colour. Arrivals of the opposite colour, and colour bits with valid low, are ignored.
- R5: Ports decide independently. A port whose queue-empty flag is low keeps the opposite colour while other ports change over.
- R6: A port that has changed over keeps the expected colour until the next clear, even if its queue-empty flag later falls.
- R7: Arrivals on different inputs in different cycles accumulate until every input has been covered.
- R8: A clear takes priority over any arrival or queue-empty flag in the same cycle. Such arrivals are discarded and are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearCmd | input | 1 | One-cycle strobe that restarts colour tracking |
| expColour | input | 1 | Programmed expected colour |
| arrValid | input | NUM_PORTS | Per-input packet-arrival strobe |
| arrColour | input | NUM_PORTS | Per-input colour bit of the arriving packet |
| queueEmpty | input | NUM_PORTS | Per-output-port queue-empty flag |
| idleColour | output | NUM_PORTS | Registered per-port idle packet colour |

## Verification
The clear strobe and the last missing expected-colour arrival, together with empty queues, can land in the same cycle. The bench provokes this by asserting clear while every input presents an expected-colour arrival and every queue is empty. It then expects all ports to show the opposite colour. One further cycle with no arrivals must also leave all ports on the opposite colour, which shows that the arrivals made alongside the clear were discarded.

// File: rtl/idle_colour_pkg.sv
package idle_colour_pkg;
  // Strobes from control to the per-port datapath
  typedef struct packed {
    logic clearAll;  // restart every port on the opposite colour
    logic allSeen;   // every input has now seen the expected colour
  } trackStrobes_t;
endpackage

// File: rtl/idle_colour_ctrl.sv
module idle_colour_ctrl
  import idle_colour_pkg::*;
#(
  parameter int NUM_INPUTS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearCmd,
  input  logic                  expColour,
  input  logic [NUM_INPUTS-1:0] arrValid,
  input  logic [NUM_INPUTS-1:0] arrColour,
  output trackStrobes_t         strobes
);
  logic [NUM_INPUTS-1:0] seenQ;
  logic [NUM_INPUTS-1:0] hitNow;
  logic [NUM_INPUTS-1:0] seenNow;

  // An arrival counts only if it carries the expected colour
  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_hit
    assign hitNow[i] = arrValid[i] & (arrColour[i] == expColour);
  end

  assign seenNow = seenQ | hitNow;

  always_ff @(posedge clk) begin
    if (!rstN)         seenQ <= '0;
    else if (clearCmd) seenQ <= '0;
    else               seenQ <= seenNow;
  end

  assign strobes.clearAll = clearCmd;
  assign strobes.allSeen  = &seenNow;

  // Clear discards same-cycle arrivals
  p_clear_drops_seen_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (seenQ == '0));

  // Recorded arrivals are never forgotten without a clear
  p_seen_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !clearCmd |=> (($past(seenQ) & ~seenQ) == '0));

  // An input newly marked seen had a matching arrival
  p_match_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !clearCmd |=> ((seenQ & ~$past(seenQ) &
                    ~($past(arrValid) & ~($past(arrColour) ^ {NUM_INPUTS{$past(expColour)}}))) == '0));
endmodule

// File: rtl/idle_colour_dp.sv
module idle_colour_dp
  import idle_colour_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trackStrobes_t        strobes,
  input  logic                 expColour,
  input  logic [NUM_PORTS-1:0] queueEmpty,
  output logic [NUM_PORTS-1:0] idleColour
);
  logic [NUM_PORTS-1:0] switchedQ;
  logic [NUM_PORTS-1:0] switchNext;
  logic [NUM_PORTS-1:0] colourQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      if (strobes.clearAll) switchNext[p] = 1'b0;
      else                  switchNext[p] = switchedQ[p] | (strobes.allSeen & queueEmpty[p]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        switchedQ[p] <= 1'b0;
        colourQ[p]   <= 1'b0;
      end else begin
        switchedQ[p] <= switchNext[p];
        colourQ[p]   <= switchNext[p] ? expColour : ~expColour;
      end
    end
  end

  assign idleColour = colourQ;

  // After a clear every port shows the opposite colour
  p_clear_opposite_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (idleColour == {NUM_PORTS{~$past(expColour)}}));

  // A port changes over only with an empty queue and all inputs seen
  p_switch_needs_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((switchedQ & ~$past(switchedQ) &
               ~($past(queueEmpty) & {NUM_PORTS{$past(strobes.allSeen)}})) == '0));

  // Changed-over ports stay there until a clear
  p_switch_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAll |=> (($past(switchedQ) & ~switchedQ) == '0));

  // Changed-over ports carry the expected colour
  p_colour_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((switchedQ & (idleColour ^ {NUM_PORTS{$past(expColour)}})) == '0));
endmodule

// File: rtl/idle_colour_tracker.sv
module idle_colour_tracker
  import idle_colour_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearCmd,
  input  logic                 expColour,
  input  logic [NUM_PORTS-1:0] arrValid,
  input  logic [NUM_PORTS-1:0] arrColour,
  input  logic [NUM_PORTS-1:0] queueEmpty,
  output logic [NUM_PORTS-1:0] idleColour
);
  trackStrobes_t strobes;

  idle_colour_ctrl #(.NUM_INPUTS(NUM_PORTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearCmd  (clearCmd),
    .expColour (expColour),
    .arrValid  (arrValid),
    .arrColour (arrColour),
    .strobes   (strobes)
  );

  idle_colour_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .expColour  (expColour),
    .queueEmpty (queueEmpty),
    .idleColour (idleColour)
  );

  // Reset leaves all outputs at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (idleColour == '0));
endmodule

// File: tb/idle_colour_tracker_tb.sv
module idle_colour_tracker_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         clearCmd;
  logic         expColour;
  logic [N-1:0] arrValid;
  logic [N-1:0] arrColour;
  logic [N-1:0] queueEmpty;
  logic [N-1:0] idleColour;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  idle_colour_tracker #(.NUM_PORTS(N)) u_dut (
    .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .expColour(expColour),
    .arrValid(arrValid), .arrColour(arrColour), .queueEmpty(queueEmpty),
    .idleColour(idleColour)
  );

  // Vector layout: {clear, exp, arrValid, arrColour, queueEmpty, expected}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 8'h00, 8'hFF, 8'h00},  // R2 clear, exp=1
    {1'b0, 1'b1, 8'h0F, 8'h0F, 8'hFF, 8'h00},  // R7 partial coverage
    {1'b0, 1'b1, 8'hF0, 8'h70, 8'hFF, 8'h00},  // R4 input7 wrong colour
    {1'b0, 1'b1, 8'h00, 8'h80, 8'hFF, 8'h00},  // R4 colour without valid
    {1'b0, 1'b1, 8'h80, 8'h80, 8'h0F, 8'h0F},  // R3/R5 last input, ports 0-3
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h30, 8'h3F},  // R5 ports 4,5 follow
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h3F},  // R6 queues fill, hold
    {1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'h00},  // R8 clear beats arrivals
    {1'b0, 1'b1, 8'h00, 8'h00, 8'hFF, 8'h00},  // R8 arrivals discarded
    {1'b1, 1'b0, 8'h00, 8'h00, 8'hFF, 8'hFF},  // R2 clear, exp=0
    {1'b0, 1'b0, 8'hFF, 8'h00, 8'h01, 8'hFE},  // R3 port0 to colour 0
    {1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00}   // R3 rest follow
  };

  task automatic check(input logic [N-1:0] exp, input string req);
    checks++;
    if (idleColour !== exp) begin
      fails++;
      $display("FAIL %s: idleColour=%h expected=%h", req, idleColour, exp);
    end
  endtask

  task automatic drive(input logic c, input logic e, input logic [N-1:0] v,
                       input logic [N-1:0] col, input logic [N-1:0] q);
    clearCmd = c; expColour = e; arrValid = v; arrColour = col; queueEmpty = q;
  endtask

  initial begin
    rstN = 1'b0;
    drive(1'b0, 1'b1, '0, '0, '1);
    repeat (3) @(negedge clk);
    check(8'h00, "R1 reset");
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][33], VEC[k][32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
      @(negedge clk);
      check(VEC[k][7:0], $sformatf("R%0s vector %0d", "x", k));
    end

    // R6 directed: switched port survives a full queue for several cycles
    drive(1'b1, 1'b1, '0, '0, '0);
    @(negedge clk);
    drive(1'b0, 1'b1, '1, '1, 8'h02);
    @(negedge clk);
    check(8'h02, "R6 port1 switched");
    drive(1'b0, 1'b1, '0, '0, '0);
    repeat (4) @(negedge clk);
    check(8'h02, "R6 port1 holds");

    // R1 directed: reset mid-run erases seen inputs and switched ports
    rstN = 1'b0;
    @(negedge clk);
    check(8'h00, "R1 reset mid-run");
    rstN = 1'b1;
    drive(1'b0, 1'b1, '0, '0, '1);
    @(negedge clk);
    check(8'h00, "R1 no stale seen after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule